// File: doc/BRIEF.md
# Dirty-Line Eviction Buffer

This block parks one evicted dirty line of an operand cache, four 32-bit longwords (16 bytes) together with the line's physical address bits 31 to 4. The cache hands over the whole line in a single cycle through a valid/ready load port. The buffer then waits until the cache reports that its own line fill has finished. Only after that does it write the line out to external memory. The fetch of the new line therefore always reaches the bus before the eviction does.

The drain is four single-longword writes on a simple request/acknowledge master port, in ascending longword order. The cache is never stalled while this happens. The only thing refused during a drain is a second eviction, held off by a low ready. The stored address is always reduced: its top three bits are forced to zero, so every emitted write address lies in the lower 512 MB.

Top module: `wb_line_buffer`

## Requirements
- R1: After reset, empty is 1, busy is 0, ld_ready is 1 and mem_req is 0.
- R2: ld_ready is high exactly while the buffer is empty. A cycle with ld_valid and ld_ready high captures ld_addr and ld_data. ld_valid while ld_ready is low is ignored: the line later drained is the one captured earlier.
- R3: After a load, mem_req stays low until fill_done has been sampled high at a clock edge. mem_req rises in the cycle right after that edge.
- R4: The line leaves as four writes, longword 0 first and longword 3 last. Beat i carries mem_addr = {stored line address, i as 2 bits, 2'b00} and mem_wdata = ld_data[32*i+31 : 32*i].
- R5: Bits 31 to 29 of mem_addr are always zero, whatever ld_addr held. ld_addr carries address bits 31 to 4, so its bits 27 to 25 are discarded.
- R6: While mem_req is high and mem_ack is low, mem_addr and mem_wdata hold their values. The beat advances only on a clock edge where both mem_req and mem_ack are high.
- R7: empty falls in the cycle after a load and rises in the cycle after the fourth acknowledged write. busy is high from the cycle after fill_done is sampled until that same fourth acknowledge.
- R8: fill_done has no effect while the buffer is empty or already draining.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Cache offers an evicted line |
| ld_ready | output | 1 | Buffer can take a line |
| ld_addr | input | 28 | Physical address bits 31..4 of the line |
| ld_data | input | 128 | Line data; longword i in bits 32*i+31..32*i |
| fill_done | input | 1 | Cache's pending line fill has completed |
| mem_req | output | 1 | Write request to external memory |
| mem_addr | output | 32 | Byte address of the current longword |
| mem_wdata | output | 32 | Current longword |
| mem_ack | input | 1 | Memory accepts the current write |
| busy | output | 1 | Write-back cycles in progress |
| empty | output | 1 | No line held |

## Verification
The embedded assertions check the following on every cycle:
- a drain starts only after a sampled fill_done;
- a pending request keeps its address and data stable;
- the top three address bits are zero during any request;
- empty returns only on the acknowledge of the last longword;
- the stored address cannot move without a load.

Only the bench's scenarios can show the rest. These cover the order and contents of the four beats against the loaded line, and refused loads leaving the held line untouched. They also cover stray fill_done pulses before a load and during a drain, under acknowledge gaps of zero, one and three cycles.

// File: rtl/wbb_pkg.sv
package wbb_pkg;
  typedef enum logic [1:0] {
    WB_IDLE  = 2'd0,
    WB_HOLD  = 2'd1,
    WB_DRAIN = 2'd2
  } wb_state_e;
endpackage

// File: rtl/wbb_line_store.sv
module wbb_line_store #(
  parameter int WORD_W   = 32,
  parameter int WORDS    = 4,
  parameter int LINE_AW  = 28,
  parameter int ZERO_TOP = 3,
  localparam int IDX_W   = $clog2(WORDS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [LINE_AW-1:0]        wr_line_addr,
  input  logic [WORDS*WORD_W-1:0]   wr_data,
  input  logic [IDX_W-1:0]          rd_idx,
  output logic [WORD_W-1:0]         rd_word,
  output logic [LINE_AW-1:0]        line_addr_q
);
  // Reduced physical address: the topmost ZERO_TOP bits are cleared.
  function automatic logic [LINE_AW-1:0] reduce_addr(input logic [LINE_AW-1:0] a);
    logic [LINE_AW-1:0] r;
    r = a;
    r[LINE_AW-1 -: ZERO_TOP] = '0;
    return r;
  endfunction

  logic [WORD_W-1:0] word_q [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     word_q[w] <= '0;
      else if (wr_en) word_q[w] <= wr_data[w*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     line_addr_q <= '0;
    else if (wr_en) line_addr_q <= reduce_addr(wr_line_addr);
  end

  assign rd_word = word_q[rd_idx];

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(line_addr_q)); // R2
endmodule

// File: rtl/wbb_seq.sv
module wbb_seq
  import wbb_pkg::*;
#(
  parameter int WORDS  = 4,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_fire,
  input  logic             fill_done,
  input  logic             beat_ack,
  output logic             is_empty,
  output logic             is_drain,
  output logic [IDX_W-1:0] beat_q,
  output logic             last_ack
);
  wb_state_e state_q, state_d;
  logic [IDX_W-1:0] beat_d;

  assign last_ack = is_drain && beat_ack && (beat_q == IDX_W'(WORDS-1));

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    unique case (state_q)
      WB_IDLE: if (load_fire) begin
        state_d = WB_HOLD;
        beat_d  = '0;
      end
      WB_HOLD: if (fill_done) state_d = WB_DRAIN;
      WB_DRAIN: if (beat_ack) begin
        beat_d = beat_q + 1'b1;
        if (last_ack) state_d = WB_IDLE;
      end
      default: state_d = WB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WB_IDLE;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
    end
  end

  assign is_empty = (state_q == WB_IDLE);
  assign is_drain = (state_q == WB_DRAIN);

  AST_DRAIN_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(is_drain) |-> $past(fill_done)); // R3
  AST_LOAD_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |=> !is_empty); // R7
  AST_EMPTY_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(is_empty) |-> $past(beat_ack && beat_q == IDX_W'(WORDS-1))); // R7
endmodule

// File: rtl/wb_line_buffer.sv
module wb_line_buffer #(
  parameter int ADDR_W   = 32,
  parameter int WORD_W   = 32,
  parameter int WORDS    = 4,
  parameter int ZERO_TOP = 3,
  localparam int IDX_W   = $clog2(WORDS),
  localparam int LANE_W  = $clog2(WORD_W/8),
  localparam int OFFS_W  = IDX_W + LANE_W,
  localparam int LINE_AW = ADDR_W - OFFS_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ld_valid,
  output logic                    ld_ready,
  input  logic [LINE_AW-1:0]      ld_addr,
  input  logic [WORDS*WORD_W-1:0] ld_data,
  input  logic                    fill_done,
  output logic                    mem_req,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [WORD_W-1:0]       mem_wdata,
  input  logic                    mem_ack,
  output logic                    busy,
  output logic                    empty
);
  // Byte address of longword idx within a stored line.
  function automatic logic [ADDR_W-1:0] beat_addr(input logic [LINE_AW-1:0] la,
                                                  input logic [IDX_W-1:0]   idx);
    return {la, idx, {LANE_W{1'b0}}};
  endfunction

  logic             load_fire;
  logic             beat_ack;
  logic             seq_empty;
  logic             seq_drain;
  logic             seq_last;
  logic [IDX_W-1:0] beat_idx;
  logic [LINE_AW-1:0] line_addr;

  assign load_fire = ld_valid && seq_empty;
  assign beat_ack  = seq_drain && mem_ack;

  wbb_seq #(.WORDS(WORDS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_fire (load_fire),
    .fill_done (fill_done),
    .beat_ack  (beat_ack),
    .is_empty  (seq_empty),
    .is_drain  (seq_drain),
    .beat_q    (beat_idx),
    .last_ack  (seq_last)
  );

  wbb_line_store #(
    .WORD_W   (WORD_W),
    .WORDS    (WORDS),
    .LINE_AW  (LINE_AW),
    .ZERO_TOP (ZERO_TOP)
  ) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (load_fire),
    .wr_line_addr (ld_addr),
    .wr_data      (ld_data),
    .rd_idx       (beat_idx),
    .rd_word      (mem_wdata),
    .line_addr_q  (line_addr)
  );

  assign ld_ready = seq_empty;
  assign empty    = seq_empty;
  assign busy     = seq_drain;
  assign mem_req  = seq_drain;
  assign mem_addr = beat_addr(line_addr, beat_idx);

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata))); // R6
  AST_ADDR_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[ADDR_W-1 -: ZERO_TOP] == '0)); // R5
  AST_LAST_BEAT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    seq_last |-> (mem_addr[OFFS_W-1:LANE_W] == IDX_W'(WORDS-1))); // R4
endmodule

// File: tb/wb_line_buffer_tb_top.sv
module wb_line_buffer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_valid = 1'b0;
  logic ld_ready;
  logic [27:0] ld_addr = '0;
  logic [127:0] ld_data = '0;
  logic fill_done = 1'b0;
  logic mem_req;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic mem_ack = 1'b0;
  logic busy;
  logic empty;

  always #2.5 clk = ~clk;

  wb_line_buffer dut_i (.*);

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_addr_q[$];
  logic [31:0] exp_data_q[$];
  int gap_cfg = 0;
  int waited = 0;
  bit prev_pend = 1'b0;
  logic [31:0] prev_addr, prev_data;

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor / scoreboard: acknowledges after gap_cfg waiting cycles.
  always @(negedge clk) begin
    if (rst_n && mem_req) begin
      if (prev_pend)
        check(mem_addr == prev_addr && mem_wdata == prev_data, "R6",
              {mem_addr, mem_wdata}, {prev_addr, prev_data});
      if (waited >= gap_cfg) begin
        mem_ack = 1'b1;
        waited = 0;
        prev_pend = 1'b0;
        if (exp_addr_q.size() == 0) begin
          check(1'b0, "R4 unexpected beat", mem_addr, 0);
        end else begin
          check(mem_addr == exp_addr_q[0], "R4/R5 addr", mem_addr, exp_addr_q[0]);
          check(mem_wdata == exp_data_q[0], "R4/R2 data", mem_wdata, exp_data_q[0]);
          void'(exp_addr_q.pop_front());
          void'(exp_data_q.pop_front());
        end
      end else begin
        mem_ack = 1'b0;
        waited++;
        prev_pend = 1'b1;
        prev_addr = mem_addr;
        prev_data = mem_wdata;
      end
    end else begin
      mem_ack = 1'b0;
      waited = 0;
      prev_pend = 1'b0;
    end
  end

  task automatic load_line(input logic [27:0] la, input logic [127:0] d,
                           input int fill_wait, input bit intrude, input bit fill_in_drain);
    while (!ld_ready) @(negedge clk);
    ld_valid = 1'b1; ld_addr = la; ld_data = d;
    @(negedge clk);
    ld_valid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      exp_addr_q.push_back({3'b000, la[24:0], i[1:0], 2'b00});
      exp_data_q.push_back(d[32*i +: 32]);
    end
    check(!empty && !busy, "R7 after load", {empty, busy}, 2'b00);
    for (int k = 0; k < fill_wait; k++) begin
      if (intrude) begin
        ld_valid = 1'b1; ld_addr = ~la; ld_data = ~d;
        check(!ld_ready, "R2 ready low", ld_ready, 0);
      end
      check(!mem_req, "R3 waiting for fill", mem_req, 0);
      @(negedge clk);
    end
    ld_valid = 1'b0;
    fill_done = 1'b1;
    @(negedge clk);
    fill_done = fill_in_drain;
    check(mem_req && busy, "R3/R7 drain starts", {mem_req, busy}, 2'b11);
    while (!empty) begin
      if (intrude) begin
        ld_valid = 1'b1; ld_addr = ~la; ld_data = ~d;
        check(!ld_ready, "R2 ready low in drain", ld_ready, 0);
      end
      check(busy, "R7 busy while draining", busy, 1);
      @(negedge clk);
    end
    ld_valid = 1'b0;
    fill_done = 1'b0;
    check(exp_addr_q.size() == 0, "R7 empty after fourth ack", exp_addr_q.size(), 0);
    check(ld_ready && !busy && !mem_req, "R2/R7 idle again", {ld_ready, busy, mem_req}, 3'b100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(empty && !busy && ld_ready && !mem_req, "R1 reset state",
          {empty, busy, ld_ready, mem_req}, 4'b1010);
    rst_n = 1'b1;
    @(negedge clk);
    check(empty && ld_ready && !mem_req, "R1 after release", {empty, ld_ready, mem_req}, 3'b110);

    // R8: stray fill_done while empty
    fill_done = 1'b1;
    repeat (3) @(negedge clk);
    check(!mem_req && empty, "R8 fill while empty", {mem_req, empty}, 2'b01);
    fill_done = 1'b0;

    gap_cfg = 0;
    load_line(28'h0123456, 128'h44444444_33333333_22222222_11111111, 3, 1'b0, 1'b0);
    gap_cfg = 1;
    load_line(28'hFFFFFFF, 128'hDEADBEEF_CAFEF00D_0BADF00D_FEEDFACE, 0, 1'b1, 1'b0);
    gap_cfg = 3;
    load_line(28'hE00ABCD, 128'h0F0F0F0F_F0F0F0F0_A5A5A5A5_5A5A5A5A, 5, 1'b1, 1'b1); // R8 in drain
    gap_cfg = 0;
    load_line(28'h1FFFFFF, 128'h00000004_00000003_00000002_00000001, 1, 1'b0, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<20000", wd);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule